// File: doc/BRIEF.md
# Video Stream Lock Qualifier

This block decides when an incoming video stream can be trusted before the link is declared running. A start pulse launches a qualification pass. PLL lock is checked first. If it is missing, the pass ends at once with an error. If it is present, the block polls a stream-clock-good input once per sample period. After that input reads good, the block turns on the video path and then polls a stream-activity input. It declares the stream stable only after a run of consecutive good samples.

Each of the two polling phases has its own bounded poll budget. When a budget runs out, the pass ends with a timeout. After success, the stable indication holds until reset or the next start pulse. A later loss of PLL lock is reported on a separate flag. Video timing generation, rate calculation and mute logic lie outside this block. They are driven only through three single-bit controls.

Top module: `vid_lock_qual`

## Requirements
- R1: A start pulse taken while `pll_locked` is low sets `pll_error` in the next cycle. The block does not poll, and `video_en`, `stream_ok` and `timeout` stay low.
- R2: The sample tick fires every TICK_CYCLES clock cycles, counted from the edge that accepts start. Poll k is taken at that edge plus k*TICK_CYCLES. In the clock phase a poll that finds `stream_clk_ok` high moves the block to the stream phase.
- R3: In the clock phase, polls 1 to POLL_LIMIT that find the clock bad only count. Poll POLL_LIMIT+1 with the clock bad ends the pass with `timeout` high.
- R4: From the clock-good poll until the pass ends, `video_en`=1, `video_mute`=0 and `slave_timing`=1. At all other times `video_en`=0, `video_mute`=1 and `slave_timing`=0. A stream timeout turns video off again.
- R5: `stream_ok` rises on the stream poll that completes RUN_GOAL+1 consecutive samples with `stream_active` high. With RUN_GOAL=10, this is the 11th good sample.
- R6: A stream poll with `stream_active` low clears the consecutive-good count to zero, so RUN_GOAL+1 fresh good samples are then needed.
- R7: The stream phase counts its own polls from zero. Stream poll POLL_LIMIT+1 that does not complete the run ends the pass with `timeout` high.
- R8: After success `stream_ok` holds whatever the inputs do. A low `pll_locked` in that state sets `lost_lock` one cycle later, and `lost_lock` stays set.
- R9: Reset and every start pulse clear `stream_ok`, `timeout`, `pll_error` and `lost_lock`, and restart the poll, run and tick counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a qualification pass |
| pll_locked | input | 1 | PLL lock indication |
| stream_clk_ok | input | 1 | Stream clock good indication, polled in the clock phase |
| stream_active | input | 1 | Stream activity indication, polled in the stream phase |
| stream_ok | output | 1 | Stream qualified as stable (sticky) |
| timeout | output | 1 | A polling phase ran out of polls |
| pll_error | output | 1 | PLL was unlocked at start |
| lost_lock | output | 1 | PLL lock dropped after success (sticky) |
| video_en | output | 1 | Enable for the video path |
| video_mute | output | 1 | Mute control, low while video is enabled |
| slave_timing | output | 1 | Selects externally supplied (slave) timing while video is enabled |

## Verification
Every result is registered, so each is due exactly one clock after the edge that samples its cause. `pll_error` follows the start edge. `lost_lock` follows the edge that sees the PLL drop. A poll result follows edge start+k*TICK_CYCLES. The bench drives inputs on falling edges and begins a pass by pulsing start across a single rising edge. Each poll task then holds its input values for exactly TICK_CYCLES clocks and samples on the falling edge after the poll's rising edge. This keeps each check in the cycle its result is due and lets the bench count polls without seeing the internal tick.

// File: rtl/vlq_pkg.sv
package vlq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLKW  = 3'd1,
    ST_STRW  = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAIL  = 3'd4
  } vlq_state_e;

  // Next consecutive-good count: a good sample extends the run, a bad one clears it.
  function automatic int unsigned run_after(input logic good, input int unsigned run);
    return good ? run + 1 : 0;
  endfunction

  // The run qualifies once it is strictly longer than the goal.
  function automatic logic run_complete(input int unsigned run, input int unsigned goal);
    return run > goal;
  endfunction

  // A phase expires when the poll number in progress exceeds the limit.
  function automatic logic poll_exhausted(input int unsigned poll_num, input int unsigned limit);
    return poll_num > limit;
  endfunction

endpackage

// File: rtl/vlq_tick_gen.sv
module vlq_tick_gen #(
  parameter int unsigned TICK_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run_en,
  output logic tick
);
  localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (run_en)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick = run_en && !restart && (cnt_q == LAST);

  generate
    if (TICK_CYCLES > 1) begin : g_spacing
      // R2: ticks never come back to back when the period exceeds one cycle
      a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/vlq_poll_counter.sv
module vlq_poll_counter #(
  parameter int unsigned POLL_LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic expire_now
);
  import vlq_pkg::*;
  localparam int unsigned PW = $clog2(POLL_LIMIT + 2);

  logic [PW-1:0] polls_q;
  logic [PW:0]   poll_num;

  assign poll_num   = {1'b0, polls_q} + 1'b1;
  assign expire_now = step && poll_exhausted(int'(poll_num), POLL_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  polls_q <= '0;
    else if (clear)              polls_q <= '0;
    else if (step && !expire_now) polls_q <= poll_num[PW-1:0];
  end

  // R3/R7: the stored poll count never runs past the limit
  a_r7_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(polls_q) <= POLL_LIMIT);

  // R9: a clear always brings the count back to zero
  a_r9_poll_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> polls_q == '0);

endmodule

// File: rtl/vlq_run_counter.sv
module vlq_run_counter #(
  parameter int unsigned RUN_GOAL = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic good,
  output logic qualify_now
);
  import vlq_pkg::*;
  localparam int unsigned RW = $clog2(RUN_GOAL + 2);

  logic [RW-1:0] run_q;
  logic [RW:0]   run_nx;

  assign run_nx      = (RW+1)'(run_after(good, int'(run_q)));
  assign qualify_now = step && run_complete(int'(run_nx), RUN_GOAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_q <= '0;
    else if (clear) run_q <= '0;
    else if (step && !qualify_now) run_q <= run_nx[RW-1:0];
  end

  // R6: a bad sample empties the run
  a_r6_bad_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !good && !clear) |=> run_q == '0);

  // R5: qualification only on a good sample
  a_r5_qualify_good: assert property (@(posedge clk) disable iff (!rst_n)
    qualify_now |-> good);

endmodule

// File: rtl/vid_lock_qual.sv
module vid_lock_qual #(
  parameter int unsigned TICK_CYCLES = 25000000,
  parameter int unsigned POLL_LIMIT  = 10,
  parameter int unsigned RUN_GOAL    = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic pll_locked,
  input  logic stream_clk_ok,
  input  logic stream_active,
  output logic stream_ok,
  output logic timeout,
  output logic pll_error,
  output logic lost_lock,
  output logic video_en,
  output logic video_mute,
  output logic slave_timing
);
  import vlq_pkg::*;

  vlq_state_e state_q, state_d;
  logic timeout_q, pll_err_q, lost_q;

  // named internal events
  logic tick_w;
  logic go_w;          // start accepted with PLL locked
  logic clk_poll_w;    // a poll in the clock phase
  logic str_poll_w;    // a poll in the stream phase
  logic clk_good_w;
  logic clk_expire_w;
  logic str_expire_w;
  logic qualify_w;
  logic polling_w;
  logic poll_clear_w;

  assign go_w       = start && pll_locked;
  assign polling_w  = (state_q == ST_CLKW) || (state_q == ST_STRW);
  assign clk_poll_w = tick_w && (state_q == ST_CLKW);
  assign str_poll_w = tick_w && (state_q == ST_STRW);
  assign clk_good_w = clk_poll_w && stream_clk_ok;
  assign poll_clear_w = start || clk_good_w;

  vlq_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(start), .run_en(polling_w), .tick(tick_w)
  );

  vlq_poll_counter #(.POLL_LIMIT(POLL_LIMIT)) u_polls (
    .clk(clk), .rst_n(rst_n), .clear(poll_clear_w),
    .step((clk_poll_w && !stream_clk_ok) || (str_poll_w && !qualify_w)),
    .expire_now(clk_expire_w)
  );

  assign str_expire_w = clk_expire_w && (state_q == ST_STRW);

  vlq_run_counter #(.RUN_GOAL(RUN_GOAL)) u_run (
    .clk(clk), .rst_n(rst_n), .clear(start), .step(str_poll_w),
    .good(stream_active), .qualify_now(qualify_w)
  );

  always_comb begin
    state_d = state_q;
    if (start) begin
      state_d = pll_locked ? ST_CLKW : ST_FAIL;
    end else begin
      unique case (state_q)
        ST_CLKW: if (clk_good_w) state_d = ST_STRW;
                 else if (clk_expire_w) state_d = ST_FAIL;
        ST_STRW: if (qualify_w) state_d = ST_DONE;
                 else if (str_expire_w) state_d = ST_FAIL;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      timeout_q <= 1'b0;
      pll_err_q <= 1'b0;
      lost_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start) begin
        timeout_q <= 1'b0;
        pll_err_q <= !pll_locked;
        lost_q    <= 1'b0;
      end else begin
        if ((state_q == ST_CLKW && clk_expire_w && !clk_good_w) || str_expire_w)
          timeout_q <= 1'b1;
        if (state_q == ST_DONE && !pll_locked)
          lost_q <= 1'b1;
      end
    end
  end

  assign stream_ok    = (state_q == ST_DONE);
  assign timeout      = timeout_q;
  assign pll_error    = pll_err_q;
  assign lost_lock    = lost_q;
  assign video_en     = (state_q == ST_STRW) || (state_q == ST_DONE);
  assign video_mute   = !video_en;
  assign slave_timing = video_en;

  // R1: a PLL error only ever follows a start taken without lock
  a_r1_pll_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_error) |-> $past(start && !pll_locked));

  // R1: start without lock never leads into polling
  a_r1_no_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pll_locked) |=> (!video_en && !stream_ok && !timeout));

  // R2: the clock phase only moves on at a tick or a start
  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLKW && !tick_w && !start) |=> state_q == ST_CLKW);

  // R4: video path controls stay consistent
  a_r4_video_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    video_en |-> (!video_mute && slave_timing));

  // R5: stable indication rises only on a good stream poll
  a_r5_ok_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stream_ok) |-> $past(tick_w && stream_active));

  // R7: success and failure flags never coexist
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(stream_ok && (timeout || pll_error)));

  // R8: success is sticky without a new start
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_ok && !start) |=> stream_ok);

endmodule

// File: tb/vid_lock_qual_tb.sv
module vid_lock_qual_tb;
  localparam int unsigned TK   = 4;
  localparam int unsigned LIM  = 20;
  localparam int unsigned GOAL = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, pll_locked = 1'b1, stream_clk_ok = 1'b0, stream_active = 1'b0;
  logic stream_ok, timeout, pll_error, lost_lock, video_en, video_mute, slave_timing;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vid_lock_qual #(.TICK_CYCLES(TK), .POLL_LIMIT(LIM), .RUN_GOAL(GOAL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pll_locked(pll_locked),
    .stream_clk_ok(stream_clk_ok), .stream_active(stream_active),
    .stream_ok(stream_ok), .timeout(timeout), .pll_error(pll_error),
    .lost_lock(lost_lock), .video_en(video_en), .video_mute(video_mute),
    .slave_timing(slave_timing)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
  endtask

  // hold inputs for one poll period, then sample after the poll edge
  task automatic poll(input logic c, input logic s);
    stream_clk_ok = c;
    stream_active = s;
    repeat (TK) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9", "stream_ok at reset", stream_ok, 1'b0);
    chk("R9", "timeout at reset", timeout, 1'b0);
    chk("R9", "pll_error at reset", pll_error, 1'b0);
    chk("R4", "video_mute at reset", video_mute, 1'b1);
    chk("R4", "video_en at reset", video_en, 1'b0);
  endtask

  task automatic t_pll_err();
    pll_locked = 1'b0;
    do_start();
    chk("R1", "pll_error after unlocked start", pll_error, 1'b1);
    chk("R1", "video_en stays low", video_en, 1'b0);
    poll(1'b1, 1'b1);
    chk("R1", "no polling after pll error", video_en, 1'b0);
    chk("R1", "no timeout after pll error", timeout, 1'b0);
    pll_locked = 1'b1;
  endtask

  task automatic t_clean_run();
    do_start();
    chk("R9", "pll_error cleared by start", pll_error, 1'b0);
    poll(1'b0, 1'b0);
    chk("R2", "bad clock poll keeps video off", video_en, 1'b0);
    poll(1'b1, 1'b0);
    chk("R2", "clock good enters stream phase", video_en, 1'b1);
    chk("R4", "mute low with video", video_mute, 1'b0);
    chk("R4", "slave timing with video", slave_timing, 1'b1);
    for (int i = 0; i < GOAL; i++) poll(1'b1, 1'b1);
    chk("R5", "not stable after GOAL good samples", stream_ok, 1'b0);
    poll(1'b1, 1'b1);
    chk("R5", "stable on GOAL+1 good sample", stream_ok, 1'b1);
    poll(1'b0, 1'b0);
    chk("R8", "stream_ok sticky", stream_ok, 1'b1);
    chk("R8", "video stays on after success", video_en, 1'b1);
  endtask

  task automatic t_restart_run();
    do_start();
    chk("R9", "stream_ok cleared by start", stream_ok, 1'b0);
    poll(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) poll(1'b1, 1'b1);
    poll(1'b1, 1'b0);
    for (int i = 0; i < GOAL; i++) poll(1'b1, 1'b1);
    chk("R6", "bad sample restarted run", stream_ok, 1'b0);
    poll(1'b1, 1'b1);
    chk("R6", "fresh run qualifies", stream_ok, 1'b1);
    chk("R7", "no timeout on success", timeout, 1'b0);
  endtask

  task automatic t_clk_timeout();
    do_start();
    for (int i = 0; i < LIM; i++) poll(1'b0, 1'b0);
    chk("R3", "no timeout within limit", timeout, 1'b0);
    poll(1'b0, 1'b0);
    chk("R3", "timeout on poll LIM+1", timeout, 1'b1);
    chk("R3", "video off on clock timeout", video_en, 1'b0);
  endtask

  task automatic t_str_timeout();
    do_start();
    chk("R9", "timeout cleared by start", timeout, 1'b0);
    // use most of the clock budget first: stream phase must start fresh
    for (int i = 0; i < LIM - 1; i++) poll(1'b0, 1'b0);
    poll(1'b1, 1'b0);
    chk("R2", "late clock good accepted", video_en, 1'b1);
    for (int i = 0; i < LIM; i++) poll(1'b1, (i % 4) != 3);
    chk("R7", "stream phase budget is its own", timeout, 1'b0);
    poll(1'b1, 1'b1);
    chk("R7", "stream timeout on poll LIM+1", timeout, 1'b1);
    chk("R4", "video off after stream timeout", video_en, 1'b0);
    chk("R4", "mute back on", video_mute, 1'b1);
  endtask

  task automatic t_lost_lock();
    do_start();
    poll(1'b1, 1'b0);
    for (int i = 0; i <= GOAL; i++) poll(1'b1, 1'b1);
    chk("R5", "qualified before lock loss", stream_ok, 1'b1);
    chk("R8", "lost_lock low while locked", lost_lock, 1'b0);
    pll_locked = 1'b0;
    @(negedge clk);
    chk("R8", "lost_lock one cycle after drop", lost_lock, 1'b1);
    pll_locked = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", "lost_lock sticky", lost_lock, 1'b1);
    chk("R8", "stream_ok kept", stream_ok, 1'b1);
    do_start();
    chk("R9", "lost_lock cleared by start", lost_lock, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pll_err();
    t_clean_run();
    t_restart_run();
    t_clk_timeout();
    t_str_timeout();
    t_lost_lock();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule